// File: doc/BRIEF.md
# Byte-Paced I2C Master Register Block

This block is the software-facing half of an I2C master that works one byte at a time. A processor programs five 8-bit registers through a simple strobed register port. The block turns those accesses into byte-level operations on an abstract bus port: a start with an address byte, a byte send, a byte receive, or a stop. Each operation is a request/done handshake that returns an acknowledge result and, for a receive, a data byte. Bit timing, pin driving and line filtering belong to a separate engine behind that port.

Progress from one byte to the next is paced by software. After each byte phase the block can raise a pending interrupt. Software then either touches the data register, which marks the clock as free, or writes the pending bit to 0, which lets the next byte move. If software clears the pending bit before the clock has been freed, the interrupt is raised again. An internal clock-free flag records whether the data register has been serviced since the last byte phase.

Register offsets (byte addresses): control 0x00, status 0x04, own address 0x08, data 0x0C, line control 0x10. Control bits: 7 acknowledge check enable, 5 interrupt enable, 4 interrupt pending. Status bits: 7:6 mode (2 = master receive, 3 = master transmit, below 2 = slave), 5 busy, 4 output enable, 0 last-bit (not acknowledged). Bus operation codes: 0 start, 1 send, 2 receive, 3 stop.

Top module: `i2c_byte_master`

## Requirements
- R1: After reset the registers read control 0x00, status 0x00, own address 0xFF, data 0xFF and line control 0x00; irq is 0 and no bus request is active.
- R2: Line control reads back all 8 written bits. A control write stores bits 7:5 and 3:0, but software can never set the pending bit (control bit 4).
- R3: An own-address write is accepted only while output enable (status bit 4) is 0. A data write is accepted only while it is 1.
- R4: A status write with output enable 1, mode bit 7 set and busy bit 5 set issues a start operation (code 0) whose byte is the current data register (bits 7:1 address, bit 0 direction). It also sets busy and clears the last-bit flag.
- R5: When a start completes with no acknowledge and control bit 7 is 1, last-bit is set and no receive follows. Otherwise, in mode 2, a receive (code 2) is issued at once. In both cases, when control bit 5 is 1, the byte phase ends with pending and irq set.
- R6: Pending and irq are set at the end of a byte phase only when interrupt enable (control bit 5) is 1. irq is never 1 while pending is 0.
- R7: A data write in mode 3 with busy set and pending clear issues a send (code 1) of the written byte at once. With pending set, the byte is only stored, and the stored value is what is sent later.
- R8: A data read returns the current data value. In mode 2 with busy set and pending clear, it also starts a receive, and the received byte replaces the data value.
- R9: Writing control with bit 4 = 0 while pending is set clears pending and irq, and clears busy if the new bit 5 is 0. If busy stays set and the clock is free, the next byte moves (a send of the data register in mode 3, a receive in mode 2). If busy stays set and the clock is not free, pending and irq are set again with no bus operation.
- R10: A status write with output enable 0 clears busy and drops irq, and issues no bus operation.
- R11: A master-mode status write with output enable 1 and busy bit 0 issues a stop (code 3) and frees the clock. Busy is cleared only if pending is clear.
- R12: A status write with output enable 1 and mode bit 7 clear stores the written bits, leaves busy unchanged and issues no bus operation.
- R13: A completed send or receive with no acknowledge sets last-bit when control bit 7 is 1. Starting a byte phase clears last-bit.
- R14: While a bus operation is outstanding, register writes and data-read side effects are ignored, and the request with its code and byte is held until done.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe (side effect on data reads) |
| reg_addr | input | ADDR_W | Register byte offset |
| reg_wdata | input | 8 | Register write data |
| reg_rdata | output | 8 | Register read data for reg_addr (combinational) |
| irq | output | 1 | Interrupt request |
| bus_req | output | 1 | Bus operation request, held until bus_done |
| bus_op | output | 2 | Operation code: 0 start, 1 send, 2 receive, 3 stop |
| bus_wdata | output | 8 | Address byte for start, data byte for send |
| bus_done | input | 1 | Operation complete, one cycle |
| bus_ack | input | 1 | 1 when the operation was acknowledged |
| bus_rdata | input | 8 | Received byte, valid with bus_done on a receive |

## Verification
A corrupted clock-free flag shows up at the next pending-bit clear. There the bus port shows either a send or receive that should not happen, or a missing one, and the control register reads pending when it should not. The result is visible within a single register write plus the bus latency. A wrong busy or last-bit value shows up on the next status read, and also decides whether a data access starts a byte. A wrong pending bit shows up on irq in the cycle after the byte phase completes. Random byte streams check the send and receive paths with both acknowledge outcomes. Directed sequences cover the re-raise, stop-with-pending, disabled-interrupt and output-disable corners.

// File: rtl/i2cbm_pkg.sv
package i2cbm_pkg;
   // register slots; byte offset of slot i is 4*i
   localparam int NREG      = 5;
   localparam int SLOT_CTRL = 0;
   localparam int SLOT_STAT = 1;
   localparam int SLOT_OWN  = 2;
   localparam int SLOT_DATA = 3;
   localparam int SLOT_LINE = 4;

   // control bits
   localparam int C_ACKEN = 7;
   localparam int C_IEN   = 5;
   localparam int C_PEND  = 4;

   // status bits
   localparam int S_BUSY = 5;
   localparam int S_OE   = 4;
   localparam int S_LAST = 0;

   localparam logic [1:0] MODE_RX = 2'b10;
   localparam logic [1:0] MODE_TX = 2'b11;

   typedef enum logic [1:0] {
      BOP_START = 2'd0,
      BOP_SEND  = 2'd1,
      BOP_RECV  = 2'd2,
      BOP_STOP  = 2'd3
   } bus_op_e;
endpackage

// File: rtl/i2cbm_decode.sv
module i2cbm_decode
   import i2cbm_pkg::*;
#(
   parameter int ADDR_W = 5
) (
   input  logic [ADDR_W-1:0] addr,
   output logic [NREG-1:0]   sel
);
   for (genvar i = 0; i < NREG; i++) begin : g_slot
      assign sel[i] = (addr == ADDR_W'(i * 4));
   end
endmodule

// File: rtl/i2cbm_bus_seq.sv
module i2cbm_bus_seq
   import i2cbm_pkg::*;
#(
   parameter int DW = 8
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          cmd_valid,
   input  bus_op_e       cmd_op,
   input  logic [DW-1:0] cmd_data,
   output logic          bus_req,
   output bus_op_e       bus_op,
   output logic [DW-1:0] bus_wdata,
   input  logic          bus_done,
   output logic          seq_busy,
   output logic          rsp_valid,
   output bus_op_e       rsp_op
);
   logic          wait_q;
   bus_op_e       op_q;
   logic [DW-1:0] data_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         wait_q <= 1'b0;
         op_q   <= BOP_STOP;
         data_q <= '0;
      end else if (cmd_valid) begin
         wait_q <= 1'b1;
         op_q   <= cmd_op;
         data_q <= cmd_data;
      end else if (wait_q && bus_done) begin
         wait_q <= 1'b0;
      end
   end

   assign bus_req   = wait_q;
   assign bus_op    = op_q;
   assign bus_wdata = data_q;
   assign seq_busy  = wait_q;
   assign rsp_valid = wait_q & bus_done;
   assign rsp_op    = op_q;

   // R14: request, code and byte held until done
   p_req_hold_r14: assert property (@(posedge clk) disable iff (!rst_n)
      bus_req && !bus_done |=> bus_req && $stable(bus_op) && $stable(bus_wdata));
endmodule

// File: rtl/i2cbm_core.sv
module i2cbm_core
   import i2cbm_pkg::*;
#(
   parameter logic [7:0] DATA_RST = 8'hFF,
   parameter logic [7:0] OWN_RST  = 8'hFF
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            wr_en,
   input  logic            rd_en,
   input  logic [NREG-1:0] sel,
   input  logic [7:0]      wdata,
   input  logic            seq_busy,
   input  logic            rsp_valid,
   input  bus_op_e         rsp_op,
   input  logic            rsp_ack,
   input  logic [7:0]      rsp_data,
   output logic [7:0]      ctrl_q,
   output logic [7:0]      stat_q,
   output logic [7:0]      own_q,
   output logic [7:0]      data_q,
   output logic [7:0]      line_q,
   output logic            irq,
   output logic            cmd_valid,
   output bus_op_e         cmd_op,
   output logic [7:0]      cmd_data
);
   logic       clkfree_q, irq_q;
   logic [7:0] n_ctrl, n_stat, n_own, n_data, n_line;
   logic       n_clkfree, n_irq;
   logic       raise, phase, acc_ok, pend, busy, oe;
   logic [1:0] mode;

   assign mode   = stat_q[7:6];
   assign busy   = stat_q[S_BUSY];
   assign oe     = stat_q[S_OE];
   assign pend   = ctrl_q[C_PEND];
   assign acc_ok = !seq_busy;

   always_comb begin
      n_ctrl    = ctrl_q;
      n_stat    = stat_q;
      n_own     = own_q;
      n_data    = data_q;
      n_line    = line_q;
      n_clkfree = clkfree_q;
      n_irq     = irq_q;
      cmd_valid = 1'b0;
      cmd_op    = BOP_STOP;
      cmd_data  = data_q;
      raise     = 1'b0;
      phase     = 1'b0;

      if (rsp_valid) begin
         unique case (rsp_op)
            BOP_START: begin
               if (!rsp_ack && ctrl_q[C_ACKEN]) begin
                  n_stat[S_LAST] = 1'b1;
                  raise          = 1'b1;
               end else if (mode == MODE_RX) begin
                  cmd_valid = 1'b1;
                  cmd_op    = BOP_RECV;
                  phase     = 1'b1;
               end else begin
                  raise = 1'b1;
               end
            end
            BOP_SEND: begin
               if (!rsp_ack && ctrl_q[C_ACKEN]) n_stat[S_LAST] = 1'b1;
               raise = 1'b1;
            end
            BOP_RECV: begin
               if (!rsp_ack && ctrl_q[C_ACKEN]) n_stat[S_LAST] = 1'b1;
               else n_data = rsp_data;
               raise = 1'b1;
            end
            default: ;
         endcase
      end else if (wr_en && acc_ok) begin
         if (sel[SLOT_CTRL]) begin
            n_ctrl = {wdata[7:5], pend, wdata[3:0]};
            if (pend && !wdata[C_PEND]) begin
               n_ctrl[C_PEND] = 1'b0;
               n_irq          = 1'b0;
               if (!wdata[C_IEN]) n_stat[S_BUSY] = 1'b0;
               if (n_stat[S_BUSY]) begin
                  if (clkfree_q) begin
                     if (mode == MODE_TX) begin
                        cmd_valid = 1'b1;
                        cmd_op    = BOP_SEND;
                        phase     = 1'b1;
                     end else if (mode == MODE_RX) begin
                        cmd_valid = 1'b1;
                        cmd_op    = BOP_RECV;
                        phase     = 1'b1;
                     end
                  end else begin
                     n_ctrl[C_PEND] = 1'b1;
                     n_irq          = 1'b1;
                  end
               end
            end
         end else if (sel[SLOT_STAT]) begin
            n_stat = {wdata[7:6], busy, wdata[4:0]};
            if (!wdata[S_OE]) begin
               n_stat[S_BUSY] = 1'b0;
               n_clkfree      = 1'b1;
               n_irq          = 1'b0;
            end else if (wdata[7]) begin
               if (wdata[S_BUSY]) begin
                  n_stat[S_LAST] = 1'b0;
                  n_stat[S_BUSY] = 1'b1;
                  n_clkfree      = 1'b0;
                  cmd_valid      = 1'b1;
                  cmd_op         = BOP_START;
               end else begin
                  cmd_valid = 1'b1;
                  cmd_op    = BOP_STOP;
                  n_clkfree = 1'b1;
                  if (!pend) n_stat[S_BUSY] = 1'b0;
               end
            end
         end else if (sel[SLOT_OWN]) begin
            if (!oe) n_own = wdata;
         end else if (sel[SLOT_DATA]) begin
            if (oe) begin
               n_data    = wdata;
               n_clkfree = 1'b1;
               if (mode == MODE_TX && busy && !pend) begin
                  cmd_valid = 1'b1;
                  cmd_op    = BOP_SEND;
                  cmd_data  = wdata;
                  phase     = 1'b1;
               end
            end
         end else if (sel[SLOT_LINE]) begin
            n_line = wdata;
         end
      end else if (rd_en && acc_ok && sel[SLOT_DATA]) begin
         n_clkfree = 1'b1;
         if (mode == MODE_RX && busy && !pend) begin
            cmd_valid = 1'b1;
            cmd_op    = BOP_RECV;
            phase     = 1'b1;
         end
      end

      if (phase) begin
         n_stat[S_LAST] = 1'b0;
         n_clkfree      = 1'b0;
      end
      if (raise && ctrl_q[C_IEN]) begin
         n_ctrl[C_PEND] = 1'b1;
         n_irq          = 1'b1;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ctrl_q    <= 8'h00;
         stat_q    <= 8'h00;
         own_q     <= OWN_RST;
         data_q    <= DATA_RST;
         line_q    <= 8'h00;
         clkfree_q <= 1'b1;
         irq_q     <= 1'b0;
      end else begin
         ctrl_q    <= n_ctrl;
         stat_q    <= n_stat;
         own_q     <= n_own;
         data_q    <= n_data;
         line_q    <= n_line;
         clkfree_q <= n_clkfree;
         irq_q     <= n_irq;
      end
   end

   assign irq = irq_q;

   // R6: irq only with pending
   p_irq_has_pend_r6: assert property (@(posedge clk) disable iff (!rst_n)
      irq_q |-> ctrl_q[C_PEND]);
   // R4: start leaves busy set
   p_start_busy_r4: assert property (@(posedge clk) disable iff (!rst_n)
      cmd_valid && cmd_op == BOP_START |=> stat_q[S_BUSY]);
   // R9: a byte phase consumes the free clock
   p_phase_clk_r9: assert property (@(posedge clk) disable iff (!rst_n)
      cmd_valid && (cmd_op == BOP_SEND || cmd_op == BOP_RECV) |=> !clkfree_q);
   // R2: software cannot set pending
   p_no_sw_pend_r2: assert property (@(posedge clk) disable iff (!rst_n)
      wr_en && sel[SLOT_CTRL] && !ctrl_q[C_PEND] && !seq_busy |=> !ctrl_q[C_PEND]);
   // R3: own address locked while output enabled
   p_own_lock_r3: assert property (@(posedge clk) disable iff (!rst_n)
      oe && !rsp_valid |=> $stable(own_q));
endmodule

// File: rtl/i2cbm_rdmux.sv
module i2cbm_rdmux
   import i2cbm_pkg::*;
(
   input  logic [NREG-1:0] sel,
   input  logic [7:0]      ctrl_q,
   input  logic [7:0]      stat_q,
   input  logic [7:0]      own_q,
   input  logic [7:0]      data_q,
   input  logic [7:0]      line_q,
   output logic [7:0]      rdata
);
   always_comb begin
      rdata = 8'h00;
      if (sel[SLOT_CTRL]) rdata = ctrl_q;
      if (sel[SLOT_STAT]) rdata = stat_q;
      if (sel[SLOT_OWN])  rdata = own_q;
      if (sel[SLOT_DATA]) rdata = data_q;
      if (sel[SLOT_LINE]) rdata = line_q;
   end
endmodule

// File: rtl/i2c_byte_master.sv
module i2c_byte_master
   import i2cbm_pkg::*;
#(
   parameter int         ADDR_W   = 5,
   parameter logic [7:0] DATA_RST = 8'hFF,
   parameter logic [7:0] OWN_RST  = 8'hFF
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              reg_wr,
   input  logic              reg_rd,
   input  logic [ADDR_W-1:0] reg_addr,
   input  logic [7:0]        reg_wdata,
   output logic [7:0]        reg_rdata,
   output logic              irq,
   output logic              bus_req,
   output logic [1:0]        bus_op,
   output logic [7:0]        bus_wdata,
   input  logic              bus_done,
   input  logic              bus_ack,
   input  logic [7:0]        bus_rdata
);
   if (ADDR_W < 5) begin : g_bad_addr_w
      $error("ADDR_W must reach offset 0x10");
   end

   logic [NREG-1:0] sel;
   logic [7:0]      ctrl_q, stat_q, own_q, data_q, line_q, cmd_data;
   logic            cmd_valid, seq_busy, rsp_valid;
   bus_op_e         cmd_op, rsp_op, op_w;

   i2cbm_decode #(.ADDR_W(ADDR_W)) u_decode (
      .addr (reg_addr),
      .sel  (sel)
   );

   i2cbm_core #(.DATA_RST(DATA_RST), .OWN_RST(OWN_RST)) u_core (
      .clk       (clk),
      .rst_n     (rst_n),
      .wr_en     (reg_wr),
      .rd_en     (reg_rd),
      .sel       (sel),
      .wdata     (reg_wdata),
      .seq_busy  (seq_busy),
      .rsp_valid (rsp_valid),
      .rsp_op    (rsp_op),
      .rsp_ack   (bus_ack),
      .rsp_data  (bus_rdata),
      .ctrl_q    (ctrl_q),
      .stat_q    (stat_q),
      .own_q     (own_q),
      .data_q    (data_q),
      .line_q    (line_q),
      .irq       (irq),
      .cmd_valid (cmd_valid),
      .cmd_op    (cmd_op),
      .cmd_data  (cmd_data)
   );

   i2cbm_bus_seq #(.DW(8)) u_seq (
      .clk       (clk),
      .rst_n     (rst_n),
      .cmd_valid (cmd_valid),
      .cmd_op    (cmd_op),
      .cmd_data  (cmd_data),
      .bus_req   (bus_req),
      .bus_op    (op_w),
      .bus_wdata (bus_wdata),
      .bus_done  (bus_done),
      .seq_busy  (seq_busy),
      .rsp_valid (rsp_valid),
      .rsp_op    (rsp_op)
   );

   assign bus_op = op_w;

   i2cbm_rdmux u_rdmux (
      .sel    (sel),
      .ctrl_q (ctrl_q),
      .stat_q (stat_q),
      .own_q  (own_q),
      .data_q (data_q),
      .line_q (line_q),
      .rdata  (reg_rdata)
   );
endmodule

// File: tb/i2c_byte_master_bench.sv
module i2c_byte_master_bench;
   localparam logic [4:0] A_CTRL = 5'h00, A_STAT = 5'h04, A_OWN = 5'h08,
                          A_DATA = 5'h0C, A_LINE = 5'h10;

   logic       clk = 1'b0, rst_n = 1'b0;
   logic       reg_wr = 1'b0, reg_rd = 1'b0;
   logic [4:0] reg_addr = '0;
   logic [7:0] reg_wdata = '0, reg_rdata;
   logic       irq, bus_req;
   logic [1:0] bus_op;
   logic [7:0] bus_wdata;
   logic       bus_done = 1'b0, bus_ack = 1'b0;
   logic [7:0] bus_rdata = '0;

   int checks = 0, errors = 0, n_ops = 0, lat = 1;
   logic       next_ack = 1'b1;
   logic [7:0] next_rd = 8'h00;
   logic [1:0] last_op = 2'd0;
   logic [7:0] last_wd = 8'h00;
   bit         done_flag = 0;

   always #5 clk = ~clk;

   i2c_byte_master u_i2c_byte_master (
      .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_rd(reg_rd),
      .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
      .irq(irq), .bus_req(bus_req), .bus_op(bus_op), .bus_wdata(bus_wdata),
      .bus_done(bus_done), .bus_ack(bus_ack), .bus_rdata(bus_rdata)
   );

   // byte-level bus responder
   initial begin
      bit seen = 0;
      int cnt = 0;
      forever begin
         @(negedge clk);
         if (bus_done) begin
            bus_done = 1'b0;
            seen = 0;
         end else if (bus_req) begin
            if (!seen) begin
               seen = 1;
               cnt = lat - 1;
            end
            if (cnt <= 0) begin
               last_op = bus_op;
               last_wd = bus_wdata;
               n_ops++;
               bus_ack = next_ack;
               bus_rdata = next_rd;
               bus_done = 1'b1;
            end else cnt--;
         end
      end
   end

   function automatic logic [7:0] exp_stat(logic [1:0] m, logic b, logic o, logic l);
      return {m, b, o, 3'b000, l};
   endfunction
   function automatic logic [7:0] exp_ctrl(logic ak, logic ie, logic p);
      return {ak, 1'b0, ie, p, 4'b0000};
   endfunction

   task automatic chk(string req, logic [7:0] act, logic [7:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s: actual %02h expected %02h", req, act, exp);
      end
   endtask

   task automatic wr(logic [4:0] a, logic [7:0] d);
      @(negedge clk);
      reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
      @(negedge clk);
      reg_wr = 1'b0;
   endtask

   task automatic rd(logic [4:0] a, output logic [7:0] v);
      @(negedge clk);
      reg_rd = 1'b1; reg_addr = a;
      #1 v = reg_rdata;
      @(negedge clk);
      reg_rd = 1'b0;
   endtask

   task automatic wait_idle();
      int quiet = 0;
      while (quiet < 3) begin
         @(negedge clk);
         if (!bus_req && !bus_done) quiet++;
         else quiet = 0;
      end
   endtask

   task automatic chk_reg(string req, logic [4:0] a, logic [7:0] exp);
      logic [7:0] v;
      rd(a, v);
      chk(req, v, exp);
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      if (!done_flag) begin
         errors++;
         checks++;
         $display("FAIL watchdog: actual hung expected finish");
         $display("Simulation finished: %0d checks, %0d errors", checks, errors);
         $finish;
      end
   end

   initial begin
      int ops0;
      logic [7:0] d, r, prev, v;
      logic a;
      void'($urandom(32'd1234));
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);

      // R1 reset state
      chk_reg("R1 ctrl", A_CTRL, 8'h00);
      chk_reg("R1 stat", A_STAT, 8'h00);
      chk_reg("R1 own", A_OWN, 8'hFF);
      chk_reg("R1 data", A_DATA, 8'hFF);
      chk_reg("R1 line", A_LINE, 8'h00);
      chk("R1 irq", {7'd0, irq}, 8'h00);
      chk("R1 req", {7'd0, bus_req}, 8'h00);

      // R2 line control and pending protection
      wr(A_LINE, 8'h3C);
      chk_reg("R2 line", A_LINE, 8'h3C);
      wr(A_CTRL, 8'hB5);
      chk_reg("R2 pend not settable", A_CTRL, 8'hA5);
      wr(A_CTRL, 8'hA0);

      // R3 and R12 write gating, slave mode
      wr(A_OWN, 8'h42);
      chk_reg("R3 own open", A_OWN, 8'h42);
      wr(A_DATA, 8'h77);
      chk_reg("R3 data locked", A_DATA, 8'hFF);
      ops0 = n_ops;
      wr(A_STAT, 8'h10);
      wait_idle();
      chk("R12 no op", 8'(n_ops - ops0), 8'h00);
      chk_reg("R12 stat", A_STAT, 8'h10);
      wr(A_OWN, 8'h99);
      chk_reg("R3 own locked", A_OWN, 8'h42);
      wr(A_DATA, 8'hA4);
      chk_reg("R3 data open", A_DATA, 8'hA4);

      // R4 R5 R6 transmit start
      next_ack = 1'b1;
      ops0 = n_ops;
      wr(A_STAT, 8'hF0);
      wait_idle();
      chk("R4 one op", 8'(n_ops - ops0), 8'h01);
      chk("R4 op start", {6'd0, last_op}, 8'h00);
      chk("R4 addr byte", last_wd, 8'hA4);
      chk_reg("R4 stat busy", A_STAT, exp_stat(2'b11, 1, 1, 0));
      chk_reg("R6 pend", A_CTRL, exp_ctrl(1, 1, 1));
      chk("R6 irq", {7'd0, irq}, 8'h01);

      // R7 store while pending
      ops0 = n_ops;
      wr(A_DATA, 8'h11);
      wait_idle();
      chk("R7 no send while pending", 8'(n_ops - ops0), 8'h00);
      chk_reg("R7 stored", A_DATA, 8'h11);

      // R9 resume with free clock
      wr(A_CTRL, 8'hA0);
      wait_idle();
      chk("R9 resume send", {6'd0, last_op}, 8'h01);
      chk("R9 resume byte", last_wd, 8'h11);
      chk_reg("R9 pend again", A_CTRL, exp_ctrl(1, 1, 1));

      // R9 re-raise with clock not free
      ops0 = n_ops;
      wr(A_CTRL, 8'hA0);
      wait_idle();
      chk("R9 re-raise no op", 8'(n_ops - ops0), 8'h00);
      chk_reg("R9 re-raise pend", A_CTRL, exp_ctrl(1, 1, 1));
      chk("R9 re-raise irq", {7'd0, irq}, 8'h01);

      // R13 random transmit stream
      d = 8'h00;
      for (int i = 0; i < 16; i++) begin
         d = 8'($urandom);
         a = 1'($urandom % 2);
         next_ack = a;
         wr(A_DATA, d);
         wr(A_CTRL, 8'hA0);
         wait_idle();
         chk("R7 random send op", {6'd0, last_op}, 8'h01);
         chk("R7 random send byte", last_wd, d);
         chk_reg("R13 last-bit", A_STAT, exp_stat(2'b11, 1, 1, ~a));
      end
      next_ack = 1'b1;

      // R11 stop with pending keeps busy
      wr(A_STAT, 8'hD0);
      wait_idle();
      chk("R11 stop op", {6'd0, last_op}, 8'h03);
      chk_reg("R11 busy kept", A_STAT, exp_stat(2'b11, 1, 1, 0));

      // R9 clear with interrupts disabled
      ops0 = n_ops;
      wr(A_CTRL, 8'h80);
      wait_idle();
      chk("R9 ien0 no op", 8'(n_ops - ops0), 8'h00);
      chk_reg("R9 ien0 busy clr", A_STAT, exp_stat(2'b11, 0, 1, 0));
      chk("R9 ien0 irq", {7'd0, irq}, 8'h00);

      // R7 immediate send, R6 no pending when disabled
      wr(A_STAT, 8'hF0);
      wait_idle();
      chk("R4 restart byte", last_wd, d);
      chk_reg("R6 no pend", A_CTRL, exp_ctrl(1, 0, 0));
      wr(A_DATA, 8'h3E);
      wait_idle();
      chk("R7 immediate op", {6'd0, last_op}, 8'h01);
      chk("R7 immediate byte", last_wd, 8'h3E);

      // R12 slave write keeps busy; R5 receive chain
      wr(A_STAT, 8'h10);
      chk_reg("R12 busy kept", A_STAT, 8'h30);
      wr(A_DATA, 8'h91);
      next_rd = 8'h5C;
      ops0 = n_ops;
      wr(A_STAT, 8'hB0);
      wait_idle();
      chk("R5 start+recv", 8'(n_ops - ops0), 8'h02);
      chk("R5 recv op", {6'd0, last_op}, 8'h02);

      // R8 random receive stream paced by data reads
      prev = 8'h5C;
      for (int i = 0; i < 12; i++) begin
         r = 8'($urandom);
         next_rd = r;
         ops0 = n_ops;
         rd(A_DATA, v);
         chk("R8 read value", v, prev);
         wait_idle();
         chk("R8 read starts recv", 8'(n_ops - ops0), 8'h01);
         prev = r;
      end

      // R11 stop without pending clears busy
      wr(A_CTRL, 8'hA0);
      wr(A_STAT, 8'h90);
      wait_idle();
      chk("R11 stop op rx", {6'd0, last_op}, 8'h03);
      chk_reg("R11 busy clr", A_STAT, exp_stat(2'b10, 0, 1, 0));

      // R5 nack on start
      next_ack = 1'b0;
      wr(A_DATA, 8'h51);
      ops0 = n_ops;
      wr(A_STAT, 8'hB0);
      wait_idle();
      chk("R5 nack no recv", 8'(n_ops - ops0), 8'h01);
      chk_reg("R5 nack last-bit", A_STAT, exp_stat(2'b10, 1, 1, 1));
      chk_reg("R5 nack pend", A_CTRL, exp_ctrl(1, 1, 1));
      chk("R5 nack irq", {7'd0, irq}, 8'h01);

      // R10 output disable
      ops0 = n_ops;
      wr(A_STAT, 8'h00);
      wait_idle();
      chk("R10 irq low", {7'd0, irq}, 8'h00);
      chk_reg("R10 busy clr", A_STAT, 8'h00);
      chk("R10 no op", 8'(n_ops - ops0), 8'h00);

      // R14 writes ignored while outstanding
      next_ack = 1'b1;
      wr(A_CTRL, 8'h80);
      wr(A_STAT, 8'h10);
      wr(A_DATA, 8'h22);
      lat = 6;
      wr(A_STAT, 8'hF0);
      wr(A_LINE, 8'h99);
      wait_idle();
      lat = 1;
      chk_reg("R14 line unchanged", A_LINE, 8'h3C);
      chk("R14 start byte", last_wd, 8'h22);

      done_flag = 1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end
endmodule